// File: doc/BRIEF.md
# Serial-Loaded Memory Bank Controller

This block sits between a CPU bus and a set of program and character ROMs and decides which bank of each ROM is visible. The CPU cannot write a bank register in one go. It writes to the upper half of its address space one bit at a time. The block collects five such bits and then stores the 5-bit result in one of four internal registers. CPU address bits 14:13 of the fifth write choose the register.

The four registers are a control word and three bank numbers. The control word holds the nametable mirroring code, the program banking mode (one 32K window, or two 16K windows with one of them fixed) and the character banking mode (one 8K window or two 4K windows). Setting data bit 7 on any upper-half write abandons a partial sequence and forces the program mode that keeps the last bank fixed at the top of the map.

The block translates the CPU and video addresses into flat ROM addresses. It also decodes an 8K work-RAM window in the CPU space.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After reset the mirroring output is 0, CPU window 0x8000–0xBFFF maps program bank 0, window 0xC000–0xFFFF maps the last program bank, and the video space maps one 8K character area starting at 4K bank 0.
- R2: A write with cpu_addr[15]=1 and data bit 7 clear shifts data bit 0 into the loader, least significant bit first. Four such writes change no output. The fifth write commits the collected 5-bit value, and the outputs reflect it from the next clock edge.
- R3: A write with cpu_addr[15]=1 and data bit 7 set discards any partial sequence and sets control bits 3:2 to 11. Control bits 4 and 1:0 are left unchanged.
- R4: On the committing write, cpu_addr[14:13] selects the register: 00 is control, 01 is character bank A, 10 is character bank B, and 11 is program bank. No other register changes.
- R5: The mirror output equals control bits 1:0. The codes are: 0 single-screen lower, 1 single-screen upper, 2 vertical, 3 horizontal.
- R6: With control bits 3:2 equal to 00 or 01, CPU addresses 0x8000–0xFFFF map one 32K area. The 16K bank number is {program value bits 3:1, cpu_addr[14]}.
- R7: With control bits 3:2 equal to 10, 0x8000–0xBFFF maps bank 0 and 0xC000–0xFFFF maps the program value.
- R8: With control bits 3:2 equal to 11, 0x8000–0xBFFF maps the program value and 0xC000–0xFFFF maps the last bank.
- R9: The block uses only bits 3:0 of the program value. Every bank number is then taken modulo the bank count, which is a power of two. prg_addr = bank*16384 + cpu_addr[13:0].
- R10: With control bit 4 clear, the video 4K bank is {bank A bits 4:1, ppu_addr[12]} modulo the 4K bank count. chr_addr = bank*4096 + ppu_addr[11:0].
- R11: With control bit 4 set, ppu_addr 0x0000–0x0FFF maps bank A and 0x1000–0x1FFF maps bank B, each taken modulo the 4K bank count.
- R12: A committing write to bank B while control bit 4 is clear leaves bank B unchanged. This becomes visible once 4K mode is selected.
- R13: cpu_addr 0x6000–0x7FFF raises wram_sel with wram_addr = cpu_addr[12:0]. Writes below 0x8000 never advance or clear the loader.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 13 | Video pattern address |
| prg_addr | output | log2(PRG_BANKS)+14 | Program ROM address |
| chr_addr | output | log2(CHR_BANKS)+12 | Character ROM address |
| mirror | output | 2 | Mirroring code |
| wram_sel | output | 1 | Work-RAM window hit |
| wram_addr | output | 13 | Work-RAM offset |

## Verification
A corrupt loader state shows at the ports in one of two ways. A value can commit after the wrong number of writes. A stale bit can also leak into the next value, which moves the bank on prg_addr or chr_addr one edge after the write that should or should not have committed.

Register faults show combinationally. A wrong control bit changes the mirror code or the window mapping on the very next address presented. A bank B register that was written in 8K mode stays invisible until 4K mode is chosen, so the bench switches modes to reveal it.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    localparam logic [4:0] SHIFT_MARK = 5'b10000;
    localparam logic [4:0] CTRL_RESET = 5'h0C;

    typedef enum logic [1:0] {
        TGT_CTRL   = 2'd0,
        TGT_CHR_LO = 2'd1,
        TGT_CHR_HI = 2'd2,
        TGT_PRG    = 2'd3
    } target_e;

    typedef struct packed {
        logic [4:0] ctrl;
        logic [4:0] chr_lo;
        logic [4:0] chr_hi;
        logic [4:0] prg;
    } bank_regs_t;
endpackage

// File: rtl/sbc_serial_loader.sv
module sbc_serial_loader
    import sbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic       din_bit,
    input  logic       din_clr,
    output logic       commit,
    output logic [4:0] value,
    output logic [4:0] shift_state
);
    logic [4:0] shift_d, shift_q;

    always_comb begin
        shift_d = shift_q;
        commit  = 1'b0;
        value   = {din_bit, shift_q[4:1]};
        if (wr_hit) begin
            if (din_clr) begin
                shift_d = SHIFT_MARK;
            end else if (shift_q[0]) begin
                // marker reached bit 0: this is the fifth bit
                commit  = 1'b1;
                shift_d = SHIFT_MARK;
            end else begin
                shift_d = value;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= SHIFT_MARK;
        else        shift_q <= shift_d;
    end

    assign shift_state = shift_q;
endmodule

// File: rtl/sbc_prg_map.sv
module sbc_prg_map #(
    parameter int PRG_BANKS = 8
) (
    input  logic [1:0]                   mode,
    input  logic [4:0]                   bank_sel,
    input  logic                         win_hi,
    output logic [$clog2(PRG_BANKS)-1:0] bank
);
    localparam int PB = $clog2(PRG_BANKS);
    localparam logic [3:0] LAST = 4'(PRG_BANKS - 1);

    logic [3:0] raw;
    logic       unused_prg_bits;

    always_comb begin
        unique case (mode)
            2'd0, 2'd1: raw = {bank_sel[3:1], win_hi};
            2'd2:       raw = win_hi ? bank_sel[3:0] : 4'd0;
            default:    raw = win_hi ? LAST : bank_sel[3:0];
        endcase
    end

    // power-of-two count: modulo is the low bits
    assign bank            = raw[PB-1:0];
    assign unused_prg_bits = ^{bank_sel[4], raw};
endmodule

// File: rtl/sbc_chr_map.sv
module sbc_chr_map #(
    parameter int CHR_BANKS = 16
) (
    input  logic                         four_k,
    input  logic [4:0]                   bank_lo,
    input  logic [4:0]                   bank_hi,
    input  logic                         half,
    output logic [$clog2(CHR_BANKS)-1:0] bank
);
    localparam int CB = $clog2(CHR_BANKS);

    logic [4:0] raw;
    logic       unused_chr_bits;

    always_comb begin
        if (four_k) raw = half ? bank_hi : bank_lo;
        else        raw = {bank_lo[4:1], half};
    end

    assign bank            = raw[CB-1:0];
    assign unused_chr_bits = ^raw;
endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
    import sbc_pkg::*;
#(
    parameter int PRG_BANKS = 8,
    parameter int CHR_BANKS = 16,
    localparam int PRG_AW = $clog2(PRG_BANKS) + 14,
    localparam int CHR_AW = $clog2(CHR_BANKS) + 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_data,
    input  logic [12:0]       ppu_addr,
    output logic [PRG_AW-1:0] prg_addr,
    output logic [CHR_AW-1:0] chr_addr,
    output logic [1:0]        mirror,
    output logic              wram_sel,
    output logic [12:0]       wram_addr
);
    bank_regs_t regs_d, regs_q;
    logic       upper_wr;
    logic       ld_commit;
    logic [4:0] ld_value;
    logic [4:0] shift_state;
    target_e    tgt;
    logic [$clog2(PRG_BANKS)-1:0] prg_bank;
    logic [$clog2(CHR_BANKS)-1:0] chr_bank;
    logic       unused_data;

    assign upper_wr    = cpu_wr & cpu_addr[15];
    assign tgt         = target_e'(cpu_addr[14:13]);
    assign unused_data = ^cpu_data[6:1];

    sbc_serial_loader u_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (upper_wr),
        .din_bit     (cpu_data[0]),
        .din_clr     (cpu_data[7]),
        .commit      (ld_commit),
        .value       (ld_value),
        .shift_state (shift_state)
    );

    always_comb begin
        regs_d = regs_q;
        if (upper_wr && cpu_data[7]) begin
            regs_d.ctrl[3:2] = 2'b11;
        end else if (ld_commit) begin
            unique case (tgt)
                TGT_CTRL:   regs_d.ctrl   = ld_value;
                TGT_CHR_LO: regs_d.chr_lo = ld_value;
                TGT_CHR_HI: if (regs_q.ctrl[4]) regs_d.chr_hi = ld_value;
                default:    regs_d.prg    = ld_value;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{ctrl: CTRL_RESET, chr_lo: 5'd0, chr_hi: 5'd0, prg: 5'd0};
        end else begin
            regs_q <= regs_d;
        end
    end

    sbc_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .mode     (regs_q.ctrl[3:2]),
        .bank_sel (regs_q.prg),
        .win_hi   (cpu_addr[14]),
        .bank     (prg_bank)
    );

    sbc_chr_map #(.CHR_BANKS(CHR_BANKS)) u_chr (
        .four_k  (regs_q.ctrl[4]),
        .bank_lo (regs_q.chr_lo),
        .bank_hi (regs_q.chr_hi),
        .half    (ppu_addr[12]),
        .bank    (chr_bank)
    );

    assign prg_addr  = {prg_bank, cpu_addr[13:0]};
    assign chr_addr  = {chr_bank, ppu_addr[11:0]};
    assign mirror    = regs_q.ctrl[1:0];
    assign wram_sel  = (cpu_addr[15:13] == 3'b011);
    assign wram_addr = cpu_addr[12:0];
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
    parameter int PRG_AW = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic              cpu_wr,
    input logic [7:0]        cpu_data,
    input logic [PRG_AW-1:0] prg_addr,
    input logic [4:0]        shift_state,
    input logic [4:0]        ctrl,
    input logic [4:0]        chr_hi
);
    // R3
    clr_forces_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15] && cpu_data[7]) |=> (shift_state == 5'b10000 && ctrl[3:2] == 2'b11));

    // R13
    low_write_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_addr[15]) |=> $stable(shift_state));

    // R4
    idle_holds_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr[15]) |=> ($stable(ctrl) && $stable(chr_hi)));

    // R12
    chr_hi_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15] && !cpu_data[7] && shift_state[0]
         && cpu_addr[14:13] == 2'b10 && !ctrl[4]) |=> $stable(chr_hi));

    // R8
    fixed_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[3:2] == 2'b11 && cpu_addr[15:14] == 2'b11) |-> (&prg_addr[PRG_AW-1:14]));

    // R7
    fixed_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[3:2] == 2'b10 && cpu_addr[15:14] == 2'b10) |-> (prg_addr[PRG_AW-1:14] == '0));
endmodule

bind serial_bank_ctrl sbc_checker #(.PRG_AW(PRG_AW)) u_sbc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_wr      (cpu_wr),
    .cpu_data    (cpu_data),
    .prg_addr    (prg_addr),
    .shift_state (shift_state),
    .ctrl        (regs_q.ctrl),
    .chr_hi      (regs_q.chr_hi)
);

// File: tb/test_serial_bank_ctrl.sv
`timescale 1ns/1ps
module test_serial_bank_ctrl;
    localparam int NPRG = 8;
    localparam int NCHR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_data = 8'h00;
    logic [12:0] ppu_addr = 13'h0000;
    logic [16:0] prg_addr;
    logic [15:0] chr_addr;
    logic [1:0]  mirror;
    logic        wram_sel;
    logic [12:0] wram_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int ctrl_m = 12, chr0_m = 0, chr1_m = 0, prg_m = 0;

    always #10 clk = ~clk;

    serial_bank_ctrl #(.PRG_BANKS(NPRG), .CHR_BANKS(NCHR)) i_serial_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
        .chr_addr(chr_addr), .mirror(mirror), .wram_sel(wram_sel),
        .wram_addr(wram_addr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_prg(input int c, input int p, input int a);
        int mode = (c >> 2) & 3;
        int w = (a >> 14) & 1;
        int b;
        if (mode < 2)       b = ((p & 14) | w) % NPRG;
        else if (mode == 2) b = w ? (p & 15) % NPRG : 0;
        else                b = w ? NPRG - 1 : (p & 15) % NPRG;
        return b * 16384 + (a & 16'h3FFF);
    endfunction

    function automatic int exp_chr(input int c, input int lo, input int hi, input int a);
        int h = (a >> 12) & 1;
        int b;
        if (((c >> 4) & 1) == 0) b = ((lo & 30) | h) % NCHR;
        else                     b = (h ? hi : lo) % NCHR;
        return b * 4096 + (a & 12'hFFF);
    endfunction

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic serial_load(input logic [15:0] a, input int v);
        for (int i = 0; i < 5; i++) bus_write(a, 8'((v >> i) & 1));
        case (a[14:13])
            2'd0: ctrl_m = v;
            2'd1: chr0_m = v;
            2'd2: if (ctrl_m[4]) chr1_m = v;
            default: prg_m = v;
        endcase
    endtask

    task automatic chk_prg(input string req, input logic [15:0] a);
        cpu_addr = a; #1;
        check(req, int'(prg_addr), exp_prg(ctrl_m, prg_m, a));
    endtask

    task automatic chk_chr(input string req, input logic [12:0] a);
        ppu_addr = a; #1;
        check(req, int'(chr_addr), exp_chr(ctrl_m, chr0_m, chr1_m, a));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        #1 check("R1 mirror", int'(mirror), 0);
        cpu_addr = 16'h8123; #1 check("R1 low window", int'(prg_addr), 16'h0123);
        cpu_addr = 16'hC456; #1 check("R1 high window", int'(prg_addr), 7 * 16384 + 16'h0456);
        ppu_addr = 13'h1ABC; #1 check("R1 chr", int'(chr_addr), 16'h1ABC);

        // R5 R6 R7 R8 R9 R4: every control value against every program value
        for (int c = 0; c < 32; c++) begin
            serial_load(16'h9FFF, c);
            #1 check("R5 mirror", int'(mirror), c & 3);
            for (int p = 0; p < 32; p++) begin
                serial_load(16'hE000 | 16'(p * 37 & 16'h1FFF), p);
                chk_prg("R6/R7/R8/R9 low", 16'h8000 | 16'(p * 101 & 16'h3FFF));
                chk_prg("R6/R7/R8/R9 high", 16'hC000 | 16'(p * 211 & 16'h3FFF));
            end
        end

        // R10 R11 R12: both character modes, all bank A and bank B values
        for (int m = 0; m < 2; m++) begin
            serial_load(16'h8000, m * 16 + 3);
            for (int lo = 0; lo < 32; lo++) begin
                for (int hi = 0; hi < 32; hi++) begin
                    serial_load(16'hA000, lo);
                    serial_load(16'hC000, hi);
                    chk_chr("R10/R11 low half", 13'(lo * 53 & 16'h0FFF));
                    chk_chr("R10/R11/R12 high half", 13'h1000 | 13'(hi * 29 & 16'h0FFF));
                end
            end
        end

        // R12: bank B written in 8K mode stays hidden, revealed in 4K mode
        serial_load(16'h8000, 5'h10);
        serial_load(16'hC000, 9);
        serial_load(16'h8000, 5'h00);
        serial_load(16'hC000, 3);
        serial_load(16'h8000, 5'h10);
        ppu_addr = 13'h1004; #1 check("R12 bank B kept", int'(chr_addr), 9 * 4096 + 4);

        // R2: four writes change nothing, fifth commits
        serial_load(16'h8000, 5'h0F);
        serial_load(16'hE000, 2);
        for (int i = 0; i < 4; i++) bus_write(16'hE000, 8'((5 >> i) & 1));
        chk_prg("R2 after four", 16'h8010);
        bus_write(16'hE000, 8'h00);
        prg_m = 5;
        chk_prg("R2 after five", 16'h8010);

        // R3: escape mid-sequence, mode forced, mirroring kept
        serial_load(16'h8000, 5'h02);
        bus_write(16'hE000, 8'h01);
        bus_write(16'hE000, 8'h01);
        bus_write(16'hE000, 8'h01);
        bus_write(16'hE000, 8'h80);
        ctrl_m = ctrl_m | 12;
        #1 check("R3 mirror kept", int'(mirror), 2);
        chk_prg("R3 forced mode", 16'hC000);
        serial_load(16'hE000, 6);
        chk_prg("R3 clean load", 16'h8777);

        // R13: work RAM window and writes below 0x8000 ignored by the loader
        cpu_addr = 16'h6000; #1 check("R13 sel lo", int'(wram_sel), 1);
        cpu_addr = 16'h7ABC; #1 check("R13 sel hi", int'(wram_sel), 1);
        check("R13 offset", int'(wram_addr), 16'h1ABC);
        cpu_addr = 16'h5FFF; #1 check("R13 below", int'(wram_sel), 0);
        cpu_addr = 16'h8000; #1 check("R13 above", int'(wram_sel), 0);
        bus_write(16'hE000, 8'h01);
        bus_write(16'hE000, 8'h00);
        for (int i = 0; i < 3; i++) bus_write(16'h6ABC, 8'h81);
        bus_write(16'hE000, 8'h00);
        bus_write(16'hE000, 8'h00);
        chk_prg("R13 not yet", 16'h8000);
        bus_write(16'hE000, 8'h00);
        prg_m = 1;
        chk_prg("R13 fifth upper write", 16'h8000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule